// File: doc/BRIEF.md
# Interrupt Context Check-In Engine

This block handles the operating-system context pull for one hardware thread. It holds the thread's context word 2. That word carries a valid flag, a save/restore flag and a virtual-processor CAM value. Software loads the word through a context write port. A pull returns the previous word and clears the valid flag.

When the global save/restore enable is on and the pulled context has its save/restore flag set, the engine checks the context back in to its virtual-processor descriptor in memory. It first reads descriptor words 0 and 1 and validates ownership and checkout state. It then writes the thread's CPPR, IPB and LSMFB into descriptor word 2. Last, it rewrites word 1 to release the checkout. A failed validation abandons the save without touching memory and reports which check failed.

All bit positions below are LSB-first, so field bit 31 is the most significant bit of a 32-bit word.

Top module: `ctx_checkin_engine`

## Requirements
- R1: A pull is accepted on a rising edge where `pull_req` and `pull_ready` are both high. The cycle after acceptance, `pull_rsp_valid` is high for one cycle and `pull_rdata` holds word 2 as it was before the pull. In word 2, bit 31 is the valid flag, bit 30 is the save/restore flag and bits 27:0 are the CAM. After reset, word 2 is zero, `busy` is low and `pull_ready` is high.
- R2: A pull clears bit 31 of word 2 and leaves bits 30:0 unchanged.
- R3: The descriptor sequence starts only when `sr_enable` is high and bit 30 of the pulled word is set. Otherwise no memory request is made and `busy` stays low.
- R4: The save reads descriptor word 0 and then word 1. The memory address is `{CAM[IDX_W-1:0], word[1:0]}`.
- R5: The checks are evaluated in a fixed priority order, and the first failure is reported:
  - word 0 bit 31 clear gives code 1;
  - word 0 bit 24 clear gives code 2;
  - word 1 bit 18 clear gives code 3;
  - a thread mismatch gives code 4.

  On a failure, `save_err` pulses for one cycle, `save_err_code` carries the code, and no descriptor write is issued.
- R6: The thread check applies only when word 1 bit 15 is set. It compares word 1 bits 14:0 against `thread_id`.
- R7: The first write goes to descriptor word 2 with byte enables `4'b1110`. Bits 31:24 carry CPPR, bits 23:16 carry IPB and bits 15:8 carry LSMFB. These values are the ones present on the `os_*` inputs in the cycle the pull was accepted.
- R8: The second write goes to descriptor word 1 with byte enables `4'b1111`. It is the word 1 that was read, with bit 18 cleared and bits 14:0 set to all ones. All other bits, including bit 15, are unchanged.
- R9: A context write replaces word 2, except when the current valid flag is set and the written bit 30 differs from the current bit 30. In that case the write is ignored.
- R10: `busy` is high from the cycle after a pull that starts the descriptor sequence until the last write or the error completes. `pull_ready` is low whenever `busy` is high.
- R11: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we`, `mem_addr`, `mem_be` and `mem_wdata` hold their values.
- R12: A context write in the same cycle as an accepted pull is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sr_enable | input | 1 | Global save/restore enable |
| thread_id | input | 15 | ID of the thread owning this context |
| os_cppr | input | 8 | Thread OS current priority |
| os_ipb | input | 8 | Thread OS pending-interrupt buffer |
| os_lsmfb | input | 8 | Thread OS LSMFB value |
| ctx_wr_en | input | 1 | Context word 2 write strobe |
| ctx_wr_data | input | 32 | Context word 2 write value |
| ctx_word2 | output | 32 | Current context word 2 |
| pull_req | input | 1 | Pull request |
| pull_ready | output | 1 | Engine idle, pull can be taken |
| pull_rsp_valid | output | 1 | Pull response strobe |
| pull_rdata | output | 32 | Word 2 prior to the pull |
| busy | output | 1 | Descriptor sequence in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | IDX_W+2 | Descriptor word address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| save_err | output | 1 | One-cycle pulse on a failed check |
| save_err_code | output | 3 | Code of the failed check |

## Verification
The bench builds the engine with `IDX_W = 4`. This gives a 16-descriptor memory model of 64 words, which the bench can preload in full and compare word by word after every save. The high CAM bits above the index are set in the tests, so the bench can show that only the low `IDX_W` bits form the address. The memory model has a latency the bench can set, either zero or several wait cycles. That brings both the back-to-back handshake and the held-request case within reach. It also leaves a window to change the `os_*` inputs after acceptance and to show that the pull snapshot is what gets written.

// File: rtl/ctx_checkin_pkg.sv
// Package: ctx_checkin_pkg
// Shared bit positions (LSB-first), state and error encodings for the
// context check-in engine. Assumes 32-bit descriptor and context words.
package ctx_checkin_pkg;

    localparam int WORD_W        = 32;
    localparam int CTX_VALID_BIT = 31;
    localparam int CTX_SR_BIT    = 30;
    localparam int CAM_W         = 28;

    localparam int D0_VALID_BIT  = 31;
    localparam int D0_HW_BIT     = 24;
    localparam int D1_CO_BIT     = 18;
    localparam int D1_TIDV_BIT   = 15;
    localparam int TID_W         = 15;

    localparam logic [1:0] WSEL_D0 = 2'd0;
    localparam logic [1:0] WSEL_D1 = 2'd1;
    localparam logic [1:0] WSEL_D2 = 2'd2;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_INVALID = 3'd1,
        ERR_NOT_HW  = 3'd2,
        ERR_NOT_CO  = 3'd3,
        ERR_THREAD  = 3'd4
    } chk_err_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RD0   = 3'd1,
        ST_RD1   = 3'd2,
        ST_CHECK = 3'd3,
        ST_WR2   = 3'd4,
        ST_WR1   = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic [7:0] cppr;
        logic [7:0] ipb;
        logic [7:0] lsmfb;
    } os_ctx_t;

endpackage

// File: rtl/ctx_word2_reg.sv
// Module: ctx_word2_reg
// Holds the thread context word 2. Accepts software writes unless they would
// flip the save/restore flag while the valid flag is set. On a pull it returns
// the old word and clears only the valid flag; a pull outranks a write.
// Assumes pull_fire is already qualified by the sequencer's ready.
module ctx_word2_reg
    import ctx_checkin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              pull_fire,
    output logic [WORD_W-1:0] word2,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data
);

    logic wr_blocked;

    // Flag a write that would change the save/restore bit of a live context.
    always_comb begin
        wr_blocked = word2[CTX_VALID_BIT] && (wr_data[CTX_SR_BIT] != word2[CTX_SR_BIT]);
    end

    // Update the context word and produce the pull response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word2     <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= pull_fire;
            if (pull_fire) begin
                rsp_data             <= word2;
                word2[CTX_VALID_BIT] <= 1'b0;
            end else if (wr_en && !wr_blocked) begin
                word2 <= wr_data;
            end
        end
    end

    AST_PULL_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        pull_fire |=> !word2[CTX_VALID_BIT]);                                // R2

    AST_SR_LOCKED_WHILE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        word2[CTX_VALID_BIT] |=> $stable(word2[CTX_SR_BIT]));                // R9

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);                                           // R1

endmodule

// File: rtl/desc_checker.sv
// Module: desc_checker
// Combinational validation of a fetched descriptor, in fixed priority order:
// valid, hardware-owned, checked-out, then thread match when the thread-ID
// valid flag is set. Assumes inputs are stable registered descriptor fields.
module desc_checker
    import ctx_checkin_pkg::*;
(
    input  logic             d0_valid,
    input  logic             d0_hw,
    input  logic             d1_co,
    input  logic             d1_tidv,
    input  logic [TID_W-1:0] d1_tid,
    input  logic [TID_W-1:0] thread_id,
    output chk_err_e         err
);

    // Report the first failing check.
    always_comb begin
        if (!d0_valid) begin
            err = ERR_INVALID;
        end else if (!d0_hw) begin
            err = ERR_NOT_HW;
        end else if (!d1_co) begin
            err = ERR_NOT_CO;
        end else if (d1_tidv && (d1_tid != thread_id)) begin
            err = ERR_THREAD;
        end else begin
            err = ERR_NONE;
        end
    end

endmodule

// File: rtl/checkin_seq.sv
// Module: checkin_seq
// Sequencer for the check-in: accepts pulls when idle, snapshots the OS
// context and thread ID, reads descriptor words 0 and 1, validates them and
// writes word 2 then word 1. Assumes a memory that holds request until ready
// and returns read data in the ready cycle.
module checkin_seq
    import ctx_checkin_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pull_req,
    input  logic               sr_enable,
    input  logic               ctx_sr,
    input  logic [IDX_W-1:0]   ctx_idx,
    input  os_ctx_t            os_ctx,
    input  logic [TID_W-1:0]   thread_id,
    output logic               pull_fire,
    output logic               pull_ready,
    output logic               busy,
    output logic               mem_req,
    output logic               mem_we,
    output logic [IDX_W+1:0]   mem_addr,
    output logic [3:0]         mem_be,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic               mem_ready,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               save_err,
    output chk_err_e           save_err_code
);

    localparam logic [TID_W-1:0] TID_ALL_ONES = '1;

    seq_state_e        state;
    logic [IDX_W-1:0]  idx_q;
    os_ctx_t           os_q;
    logic [TID_W-1:0]  tid_q;
    logic              d0_valid_q;
    logic              d0_hw_q;
    logic [WORD_W-1:0] w1_q;
    logic              w2_done;
    logic              chk_pass_q;
    logic [1:0]        wsel;
    chk_err_e          chk_err;

    desc_checker u_desc_checker (
        .d0_valid  (d0_valid_q),
        .d0_hw     (d0_hw_q),
        .d1_co     (w1_q[D1_CO_BIT]),
        .d1_tidv   (w1_q[D1_TIDV_BIT]),
        .d1_tid    (w1_q[TID_W-1:0]),
        .thread_id (tid_q),
        .err       (chk_err)
    );

    // Pull acceptance and busy indication.
    always_comb begin
        pull_ready = (state == ST_IDLE);
        pull_fire  = pull_req && pull_ready;
        busy       = (state != ST_IDLE);
    end

    // Drive the memory request from the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        wsel      = WSEL_D0;
        mem_be    = 4'b1111;
        mem_wdata = '0;
        unique case (state)
            ST_RD0: begin
                mem_req = 1'b1;
                wsel    = WSEL_D0;
            end
            ST_RD1: begin
                mem_req = 1'b1;
                wsel    = WSEL_D1;
            end
            ST_WR2: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                wsel      = WSEL_D2;
                mem_be    = 4'b1110;
                mem_wdata = {os_q.cppr, os_q.ipb, os_q.lsmfb, 8'h00};
            end
            ST_WR1: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                wsel      = WSEL_D1;
                mem_wdata = w1_q;
                mem_wdata[D1_CO_BIT]  = 1'b0;
                mem_wdata[TID_W-1:0]  = TID_ALL_ONES;
            end
            default: ;
        endcase
        mem_addr = {idx_q, wsel};
    end

    // Step through read, check and ordered write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            idx_q         <= '0;
            os_q          <= '0;
            tid_q         <= '0;
            d0_valid_q    <= 1'b0;
            d0_hw_q       <= 1'b0;
            w1_q          <= '0;
            w2_done       <= 1'b0;
            chk_pass_q    <= 1'b0;
            save_err      <= 1'b0;
            save_err_code <= ERR_NONE;
        end else begin
            save_err <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (pull_fire) begin
                        idx_q <= ctx_idx;
                        os_q  <= os_ctx;
                        tid_q <= thread_id;
                        if (sr_enable && ctx_sr) begin
                            state <= ST_RD0;
                        end
                    end
                end
                ST_RD0: begin
                    if (mem_ready) begin
                        d0_valid_q <= mem_rdata[D0_VALID_BIT];
                        d0_hw_q    <= mem_rdata[D0_HW_BIT];
                        state      <= ST_RD1;
                    end
                end
                ST_RD1: begin
                    if (mem_ready) begin
                        w1_q  <= mem_rdata;
                        state <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (chk_err != ERR_NONE) begin
                        save_err      <= 1'b1;
                        save_err_code <= chk_err;
                        state         <= ST_IDLE;
                    end else begin
                        chk_pass_q <= 1'b1;
                        state      <= ST_WR2;
                    end
                end
                ST_WR2: begin
                    if (mem_ready) begin
                        w2_done <= 1'b1;
                        state   <= ST_WR1;
                    end
                end
                ST_WR1: begin
                    if (mem_ready) begin
                        w2_done    <= 1'b0;
                        chk_pass_q <= 1'b0;
                        state      <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_START_NEEDS_SR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(sr_enable && ctx_sr && pull_req));             // R3

    AST_NO_WRITE_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> chk_pass_q);                                 // R5

    AST_W1_AFTER_W2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && (mem_addr[1:0] == WSEL_D1)) |-> w2_done);      // R8

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                      && $stable(mem_be) && $stable(mem_wdata))); // R11

    AST_BUSY_BLOCKS_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !pull_ready);                                               // R10

endmodule

// File: rtl/ctx_checkin_engine.sv
// Module: ctx_checkin_engine
// Top of the context check-in engine: the context word 2 register plus the
// descriptor sequencer. Assumes a single thread context per instance and a
// word-addressed descriptor memory of four words per descriptor.
module ctx_checkin_engine
    import ctx_checkin_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sr_enable,
    input  logic [14:0]        thread_id,
    input  logic [7:0]         os_cppr,
    input  logic [7:0]         os_ipb,
    input  logic [7:0]         os_lsmfb,
    input  logic               ctx_wr_en,
    input  logic [31:0]        ctx_wr_data,
    output logic [31:0]        ctx_word2,
    input  logic               pull_req,
    output logic               pull_ready,
    output logic               pull_rsp_valid,
    output logic [31:0]        pull_rdata,
    output logic               busy,
    output logic               mem_req,
    output logic               mem_we,
    output logic [IDX_W+1:0]   mem_addr,
    output logic [3:0]         mem_be,
    output logic [31:0]        mem_wdata,
    input  logic               mem_ready,
    input  logic [31:0]        mem_rdata,
    output logic               save_err,
    output logic [2:0]         save_err_code
);

    logic     pull_fire;
    os_ctx_t  os_ctx;
    chk_err_e err_code;

    // Bundle the thread OS registers.
    always_comb begin
        os_ctx = '{cppr: os_cppr, ipb: os_ipb, lsmfb: os_lsmfb};
    end

    ctx_word2_reg u_word2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ctx_wr_en),
        .wr_data   (ctx_wr_data),
        .pull_fire (pull_fire),
        .word2     (ctx_word2),
        .rsp_valid (pull_rsp_valid),
        .rsp_data  (pull_rdata)
    );

    checkin_seq #(.IDX_W(IDX_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .pull_req      (pull_req),
        .sr_enable     (sr_enable),
        .ctx_sr        (ctx_word2[CTX_SR_BIT]),
        .ctx_idx       (ctx_word2[IDX_W-1:0]),
        .os_ctx        (os_ctx),
        .thread_id     (thread_id),
        .pull_fire     (pull_fire),
        .pull_ready    (pull_ready),
        .busy          (busy),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_be        (mem_be),
        .mem_wdata     (mem_wdata),
        .mem_ready     (mem_ready),
        .mem_rdata     (mem_rdata),
        .save_err      (save_err),
        .save_err_code (err_code)
    );

    assign save_err_code = err_code;

    AST_ERR_CODE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        save_err |-> (save_err_code != 3'd0));                               // R5

endmodule

// File: tb/ctx_checkin_engine_bench.sv
// Directed bench for ctx_checkin_engine with a latency-configurable memory model.
module ctx_checkin_engine_bench;

    localparam int IDX_W = 4;
    localparam int NWORD = 4 << IDX_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sr_enable = 1'b0;
    logic [14:0] thread_id = 15'h1234;
    logic [7:0]  os_cppr = 8'h00, os_ipb = 8'h00, os_lsmfb = 8'h00;
    logic        ctx_wr_en = 1'b0;
    logic [31:0] ctx_wr_data = '0;
    logic [31:0] ctx_word2;
    logic        pull_req = 1'b0;
    logic        pull_ready, pull_rsp_valid, busy;
    logic [31:0] pull_rdata;
    logic        mem_req, mem_we, mem_ready;
    logic [IDX_W+1:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, mem_rdata;
    logic        save_err;
    logic [2:0]  save_err_code;

    ctx_checkin_engine #(.IDX_W(IDX_W)) u_ctx_checkin_engine (
        .clk(clk), .rst_n(rst_n), .sr_enable(sr_enable), .thread_id(thread_id),
        .os_cppr(os_cppr), .os_ipb(os_ipb), .os_lsmfb(os_lsmfb),
        .ctx_wr_en(ctx_wr_en), .ctx_wr_data(ctx_wr_data), .ctx_word2(ctx_word2),
        .pull_req(pull_req), .pull_ready(pull_ready), .pull_rsp_valid(pull_rsp_valid),
        .pull_rdata(pull_rdata), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .save_err(save_err),
        .save_err_code(save_err_code)
    );

    always #10 clk = ~clk;   // 50 MHz

    // ---------------- memory model ----------------
    logic [31:0] mem [NWORD];
    int          mem_lat = 0;
    int          lat_cnt = 0;

    assign mem_ready = mem_req && (lat_cnt >= mem_lat);
    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (!rst_n || !mem_req || mem_ready) lat_cnt <= 0;
        else                                 lat_cnt <= lat_cnt + 1;
        if (rst_n && mem_req && mem_ready && mem_we) begin
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
        end
    end

    // ---------------- observers (sampled at negedge) ----------------
    int          log_n = 0;
    logic [IDX_W+1:0] log_addr [8];
    logic        log_we [8];
    logic [3:0]  log_be [8];
    int          err_cnt = 0;
    logic [2:0]  err_last = '0;
    int          hold_viol = 0;
    logic        prev_stall = 1'b0;
    logic [IDX_W+1:0] prev_addr = '0;
    logic [31:0] prev_wdata = '0;
    logic        prev_we = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && mem_ready) begin
                if (log_n < 8) begin
                    log_addr[log_n] = mem_addr;
                    log_we[log_n]   = mem_we;
                    log_be[log_n]   = mem_be;
                end
                log_n++;
            end
            if (save_err) begin
                err_cnt++;
                err_last = save_err_code;
            end
            if (prev_stall && !(mem_req && mem_addr == prev_addr &&
                                mem_we == prev_we && mem_wdata == prev_wdata))
                hold_viol++;
            prev_stall = mem_req && !mem_ready;
            prev_addr  = mem_addr;
            prev_we    = mem_we;
            prev_wdata = mem_wdata;
        end
    end

    // ---------------- check bookkeeping ----------------
    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic ctx_write(input logic [31:0] d);
        @(negedge clk);
        ctx_wr_en   = 1'b1;
        ctx_wr_data = d;
        @(negedge clk);
        ctx_wr_en   = 1'b0;
    endtask

    // Issue a pull, wait for acceptance, return response seen one cycle later.
    task automatic do_pull(output logic [31:0] rd, output logic rv);
        @(negedge clk);
        pull_req = 1'b1;
        while (!pull_ready) @(negedge clk);
        @(negedge clk);
        pull_req = 1'b0;
        rd = pull_rdata;
        rv = pull_rsp_valid;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic int a(input int idx, input int w);
        return idx * 4 + w;
    endfunction

    task automatic load_desc(input int idx, input logic [31:0] w0, w1, w2);
        mem[a(idx,0)] = w0;
        mem[a(idx,1)] = w1;
        mem[a(idx,2)] = w2;
        mem[a(idx,3)] = 32'hD3D3_0000 | idx;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(ctx_word2 == 0, "R1", "reset word2", ctx_word2, 0);
        chk(!busy && pull_ready, "R1", "reset busy/ready", {busy, pull_ready}, 32'h1);
        chk(!mem_req && !save_err, "R1", "reset mem_req/err", {mem_req, save_err}, 0);
    endtask

    task automatic t_write_guard();
        ctx_write(32'hC000_0005);
        chk(ctx_word2 == 32'hC000_0005, "R9", "write accepted", ctx_word2, 32'hC000_0005);
        ctx_write(32'h8000_0007);   // sr flip while valid
        chk(ctx_word2 == 32'hC000_0005, "R9", "sr flip ignored", ctx_word2, 32'hC000_0005);
        ctx_write(32'hC000_0009);   // same sr, new cam
        chk(ctx_word2 == 32'hC000_0009, "R9", "same sr accepted", ctx_word2, 32'hC000_0009);
    endtask

    task automatic t_pull_no_save();
        logic [31:0] rd; logic rv;
        sr_enable = 1'b0;
        log_n = 0;
        ctx_write(32'hC123_4569);
        do_pull(rd, rv);
        chk(rv, "R1", "rsp valid", rv, 1);
        chk(rd == 32'hC123_4569, "R1", "old word returned", rd, 32'hC123_4569);
        chk(ctx_word2 == 32'h4123_4569, "R2", "valid cleared only", ctx_word2, 32'h4123_4569);
        repeat (4) @(negedge clk);
        chk(log_n == 0 && !busy, "R3", "no access sr_enable=0", log_n, 0);
        // valid now clear: sr flip allowed
        ctx_write(32'h0123_4569);
        chk(ctx_word2 == 32'h0123_4569, "R9", "sr change when invalid", ctx_word2, 32'h0123_4569);
        sr_enable = 1'b1;
        ctx_write(32'h8000_0003);   // valid, sr=0
        do_pull(rd, rv);
        repeat (4) @(negedge clk);
        chk(log_n == 0 && !busy, "R3", "no access sr bit=0", log_n, 0);
    endtask

    task automatic t_save_ok();
        logic [31:0] rd; logic rv;
        logic [31:0] w1 = 32'h0014_9234;   // co bit18, tidv bit15, tid 0x1234, bit20
        sr_enable = 1'b1;
        mem_lat   = 2;
        thread_id = 15'h1234;
        load_desc(5, 32'h8100_0000, w1, 32'hAAAA_AA5C);
        os_cppr = 8'h11; os_ipb = 8'h22; os_lsmfb = 8'h33;
        ctx_write(32'hCAB0_0005);          // high CAM bits set, index 5
        log_n = 0;
        do_pull(rd, rv);
        os_cppr = 8'h99; os_ipb = 8'h88; os_lsmfb = 8'h77;   // after snapshot
        chk(busy && !pull_ready, "R10", "busy blocks pull", {busy, pull_ready}, 32'h2);
        wait_idle();
        chk(log_n == 4, "R4", "access count", log_n, 4);
        chk(log_addr[0] == a(5,0) && !log_we[0], "R4", "first read word0", log_addr[0], a(5,0));
        chk(log_addr[1] == a(5,1) && !log_we[1], "R4", "second read word1", log_addr[1], a(5,1));
        chk(log_addr[2] == a(5,2) && log_we[2] && log_be[2] == 4'b1110, "R7", "first write w2 be",
            {log_addr[2], log_be[2]}, {a(5,2), 4'b1110});
        chk(log_addr[3] == a(5,1) && log_we[3] && log_be[3] == 4'b1111, "R8", "second write w1",
            {log_addr[3], log_be[3]}, {a(5,1), 4'b1111});
        chk(mem[a(5,2)] == 32'h1122_335C, "R7", "word2 content", mem[a(5,2)], 32'h1122_335C);
        chk(mem[a(5,1)] == 32'h0010_FFFF, "R8", "word1 content", mem[a(5,1)], 32'h0010_FFFF);
        chk(mem[a(5,0)] == 32'h8100_0000, "R8", "word0 untouched", mem[a(5,0)], 32'h8100_0000);
        chk(err_cnt == 0, "R5", "no error on pass", err_cnt, 0);
        chk(!busy && pull_ready, "R10", "idle after writes", busy, 0);
    endtask

    task automatic t_back_pressure();
        logic [31:0] rd; logic rv;
        int e0;
        // descriptor 5 is no longer checked out: second pull must fail with code 3
        mem_lat = 3;
        ctx_write(32'hC000_0005);
        load_desc(5, 32'h8100_0000, 32'h0014_9234, 32'h0);
        log_n = 0;
        e0 = err_cnt;
        do_pull(rd, rv);
        do_pull(rd, rv);                   // queued behind the first save
        chk(log_n == 4, "R10", "second pull waited for writes", log_n, 4);
        chk(rd == 32'h4000_0005, "R10", "second pull response", rd, 32'h4000_0005);
        wait_idle();
        chk(err_cnt == e0 + 1 && err_last == 3, "R5", "not checked out code", err_last, 3);
        chk(log_n == 6, "R5", "no write on fail", log_n, 6);
        chk(hold_viol == 0, "R11", "request held under stall", hold_viol, 0);
    endtask

    task automatic t_err_one(input logic [31:0] w0, w1, input logic [2:0] code,
                             input string req, input string what);
        logic [31:0] rd; logic rv;
        int e0;
        load_desc(7, w0, w1, 32'h5555_5555);
        ctx_write(32'hC000_0007);
        log_n = 0;
        e0 = err_cnt;
        do_pull(rd, rv);
        wait_idle();
        chk(err_cnt == e0 + 1 && err_last == code, req, what, err_last, code);
        chk(log_n == 2 && mem[a(7,2)] == 32'h5555_5555 && mem[a(7,1)] == w1, req,
            {what, " no write"}, log_n, 2);
    endtask

    task automatic t_errors();
        logic [31:0] rd; logic rv;
        mem_lat   = 0;
        thread_id = 15'h0042;
        t_err_one(32'h0000_0000, 32'h0004_0042, 3'd1, "R5", "invalid (and not hw) code1");
        t_err_one(32'h8000_0000, 32'h0004_0042, 3'd2, "R5", "not hw code2");
        t_err_one(32'h8100_0000, 32'h0000_8042, 3'd3, "R5", "not co code3");
        t_err_one(32'h8100_0000, 32'h0004_8043, 3'd4, "R6", "thread mismatch code4");
        // mismatched thread but tid-valid clear: save proceeds
        load_desc(7, 32'h8100_0000, 32'h0004_0043, 32'h0);
        os_cppr = 8'hA1; os_ipb = 8'hB2; os_lsmfb = 8'hC3;
        ctx_write(32'hC000_0007);
        log_n = 0;
        do_pull(rd, rv);
        wait_idle();
        chk(log_n == 4 && mem[a(7,1)] == 32'h0000_7FFF, "R6", "tid check skipped", mem[a(7,1)], 32'h0000_7FFF);
        chk(mem[a(7,2)] == 32'hA1B2_C300, "R7", "w2 low byte kept", mem[a(7,2)], 32'hA1B2_C300);
    endtask

    task automatic t_pull_vs_write();
        sr_enable = 1'b0;
        ctx_write(32'h8000_0001);
        @(negedge clk);
        pull_req    = 1'b1;
        ctx_wr_en   = 1'b1;
        ctx_wr_data = 32'h8000_000E;
        @(negedge clk);
        pull_req  = 1'b0;
        ctx_wr_en = 1'b0;
        chk(pull_rdata == 32'h8000_0001, "R12", "pull response", pull_rdata, 32'h8000_0001);
        chk(ctx_word2 == 32'h0000_0001, "R12", "write dropped", ctx_word2, 32'h0000_0001);
    endtask

    bit done = 1'b0;

    initial begin
        for (int i = 0; i < NWORD; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_guard();
        t_pull_no_save();
        t_save_ok();
        t_back_pressure();
        t_errors();
        t_pull_vs_write();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule